// File: doc/BRIEF.md
# Auto-Baud Half-Duplex Serial Receiver

This block listens on a single shared serial line and turns it into bytes without a configured baud rate. Every datagram opens with a byte whose four lowest bits carry a fixed 1,0,1,0 pattern. The receiver times the span from the start-bit edge to the third falling edge, which covers four bit times, and keeps that period for every byte that follows in the datagram. Each byte is framed by a low start bit and a high stop bit. Its data bits arrive least significant first and are sampled at mid-bit, timed from that byte's start edge.

The receiver also guards the line. A short low pulse on the idle line is discarded as a glitch. A rate faster than the supported minimum period is rejected. A sync whose edges never arrive is abandoned once the period counter saturates, and a low stop bit is a framing error. When the gap between two start bits grows too long, the stream is dropped and the next byte is treated as a new datagram. Every such error is followed by a stretch of enforced idle time, counted in measured bit periods, before a start bit is accepted again. Datagram decoding, CRC checking and driving the line are handled elsewhere. The line input must already be synchronous to the clock.

Top module: `autobaud_line_rx`

## Requirements
- R1: A received byte appears on `byte_o` with bit 0 taken from the first data bit on the line. `byte_valid_o` is high for exactly one cycle per byte.
- R2: On the first byte of a datagram, `bit_period_o` takes the number of clocks from the start-bit falling edge to the third falling edge, divided by 4. That byte is delivered in full, including the three sync bits, with `frame_start_o` high.
- R3: Later bytes in the same datagram are sampled at the midpoint of each bit using the stored period, and they carry `frame_start_o` low.
- R4: If the measured span is shorter than 4*MIN_PERIOD clocks (64 by default), `error_o` pulses and `bit_period_o` keeps its previous value.
- R5: A start bit that arrives exactly PAUSE_BITS (63) bit periods after the previous start bit continues the datagram. If more time passes than that, `error_o` pulses and the receiver goes back to waiting for a new datagram.
- R6: After any error, a start bit is ignored until the line has stayed high for RECOV_BITS (12) bit periods in a row. Any low level restarts this count.
- R7: A low pulse on an idle line that lasts fewer than GLITCH_CYC (16) clocks makes `error_o` pulse. A pulse of 16 clocks is not a glitch.
- R8: A stop bit sampled low makes `error_o` pulse and delivers no byte.
- R9: If the third sync edge has not arrived 2^(PW+2)-1 clocks after the start edge (16383 by default), `error_o` pulses.
- R10: After reset, `byte_valid_o`, `frame_start_o` and `error_o` are low and `bit_period_o` equals INIT_PERIOD (16).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | 1 | Serial line, already synchronous, idle high |
| byte_o | output | DW | Last received byte |
| byte_valid_o | output | 1 | One-cycle strobe for `byte_o` |
| frame_start_o | output | 1 | High with the strobe of a datagram's first byte |
| error_o | output | 1 | One-cycle pulse on any receive error |
| bit_period_o | output | PW | Current bit period in clocks |

## Verification
The assertions check properties that hold on every cycle. The byte strobe is a single-cycle pulse, and the datagram-start marker only ever appears with it. A byte strobe and an error never coincide. Any new period value is at or above the minimum. The recovery state can only lead back to idle. A pause count never runs past the timeout limit. Only the bench scenarios can show the remaining behaviour: mid-bit sampling at several rates, the exact 63-period boundary, the 15- and 16-clock glitch limit, rejection of a too-fast sync, saturation, framing errors, and bytes being ignored during recovery.

// File: rtl/abr_pkg.sv
package abr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SYNC,
    ST_DATA,
    ST_GAP,
    ST_RECOV
  } rx_state_e;
endpackage

// File: rtl/abr_edge_det.sv
module abr_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic fall_o
);
  logic line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) line_q <= 1'b1;
    else         line_q <= line_i;
  end

  assign fall_o = line_q & ~line_i;
endmodule

// File: rtl/abr_limits.sv
module abr_limits #(
  parameter int PW         = 12,
  parameter int CW         = 19,
  parameter int RW         = 16,
  parameter int PAUSE_BITS = 63,
  parameter int RECOV_BITS = 12
) (
  input  logic [PW-1:0] period_i,
  output logic [CW-1:0] first_o,
  output logic [CW-1:0] pause_o,
  output logic [RW-1:0] recov_o
);
  logic [CW-1:0] half;

  assign half    = CW'(period_i >> 1);
  assign first_o = CW'(period_i) + half;
  assign pause_o = CW'(period_i) * CW'(PAUSE_BITS);
  assign recov_o = RW'(period_i) * RW'(RECOV_BITS);
endmodule

// File: rtl/abr_shreg.sv
module abr_shreg #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          preset_i,
  input  logic          shift_i,
  input  logic          bit_i,
  input  logic          commit_i,
  input  logic          sof_i,
  output logic [DW-1:0] byte_o,
  output logic          valid_o,
  output logic          sof_o
);
  // sync bits 2,1,0 already known when the period is measured
  localparam logic [2:0] SYNC_HEAD = 3'b101;

  logic [DW-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      byte_o  <= '0;
      valid_o <= 1'b0;
      sof_o   <= 1'b0;
    end else begin
      valid_o <= commit_i;
      sof_o   <= commit_i & sof_i;
      if (commit_i) byte_o <= sh_q;
      if (preset_i)     sh_q <= {SYNC_HEAD, {(DW-3){1'b0}}};
      else if (shift_i) sh_q <= {bit_i, sh_q[DW-1:1]};
    end
  end
endmodule

// File: rtl/autobaud_line_rx.sv
module autobaud_line_rx
  import abr_pkg::*;
#(
  parameter int PW          = 12,
  parameter int DW          = 8,
  parameter int MIN_PERIOD  = 16,
  parameter int GLITCH_CYC  = 16,
  parameter int PAUSE_BITS  = 63,
  parameter int RECOV_BITS  = 12,
  parameter int INIT_PERIOD = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          line_i,
  output logic [DW-1:0] byte_o,
  output logic          byte_valid_o,
  output logic          frame_start_o,
  output logic          error_o,
  output logic [PW-1:0] bit_period_o
);
  localparam int CW = PW + $clog2(PAUSE_BITS + 2);
  localparam int RW = PW + $clog2(RECOV_BITS + 1);
  localparam int IW = $clog2(DW + 1);
  localparam logic [CW-1:0] SYNC_LAST  = CW'((64'd1 << (PW + 2)) - 64'd1);
  localparam logic [CW-1:0] MIN_SYNC   = CW'(4 * MIN_PERIOD);
  localparam logic [CW-1:0] GLITCH_LIM = CW'(GLITCH_CYC);
  localparam logic [IW-1:0] SYNC_KNOWN = IW'(3);
  localparam logic [IW-1:0] STOP_IDX   = IW'(DW);

  rx_state_e     state_q, state_d;
  logic [CW-1:0] cyc_q, cyc_d, tgt_q, tgt_d;
  logic [PW-1:0] period_q, period_d;
  logic [RW-1:0] rcnt_q, rcnt_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          fcnt_q, fcnt_d, first_q, first_d, err_q;
  logic          err_set, preset, shift, commit, fall;
  logic [CW-1:0] first_lim, pause_lim;
  logic [RW-1:0] recov_lim;

  abr_edge_det u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (line_i),
    .fall_o (fall)
  );

  abr_limits #(
    .PW(PW), .CW(CW), .RW(RW), .PAUSE_BITS(PAUSE_BITS), .RECOV_BITS(RECOV_BITS)
  ) u_lim (
    .period_i (period_q),
    .first_o  (first_lim),
    .pause_o  (pause_lim),
    .recov_o  (recov_lim)
  );

  abr_shreg #(.DW(DW)) u_sh (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .preset_i (preset),
    .shift_i  (shift),
    .bit_i    (line_i),
    .commit_i (commit),
    .sof_i    (first_q),
    .byte_o   (byte_o),
    .valid_o  (byte_valid_o),
    .sof_o    (frame_start_o)
  );

  always_comb begin
    state_d  = state_q;
    cyc_d    = cyc_q;
    tgt_d    = tgt_q;
    period_d = period_q;
    rcnt_d   = rcnt_q;
    idx_d    = idx_q;
    fcnt_d   = fcnt_q;
    first_d  = first_q;
    err_set  = 1'b0;
    preset   = 1'b0;
    shift    = 1'b0;
    commit   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (fall) begin
          state_d = ST_SYNC;
          cyc_d   = CW'(1);
          fcnt_d  = 1'b0;
        end
      end
      ST_SYNC: begin
        cyc_d = cyc_q + CW'(1);
        if (line_i && cyc_q < GLITCH_LIM) begin
          err_set = 1'b1;
        end else if (fall) begin
          if (!fcnt_q) begin
            fcnt_d = 1'b1;
          end else if (cyc_q < MIN_SYNC) begin
            err_set = 1'b1;
          end else begin
            // span covers four bit times
            period_d = cyc_q[PW+1:2];
            tgt_d    = cyc_q + CW'(cyc_q[PW+1:3]);
            idx_d    = SYNC_KNOWN;
            preset   = 1'b1;
            first_d  = 1'b1;
            state_d  = ST_DATA;
          end
        end else if (cyc_q == SYNC_LAST) begin
          err_set = 1'b1;
        end
      end
      ST_DATA: begin
        cyc_d = cyc_q + CW'(1);
        if (line_i && cyc_q < GLITCH_LIM) begin
          err_set = 1'b1;
        end else if (cyc_q == tgt_q) begin
          if (idx_q == STOP_IDX) begin
            if (line_i) begin
              commit  = 1'b1;
              first_d = 1'b0;
              state_d = ST_GAP;
            end else begin
              err_set = 1'b1;
            end
          end else begin
            shift = 1'b1;
            idx_d = idx_q + IW'(1);
            tgt_d = tgt_q + CW'(period_q);
          end
        end
      end
      ST_GAP: begin
        cyc_d = cyc_q + CW'(1);
        if (cyc_q > pause_lim) begin
          err_set = 1'b1;
        end else if (fall) begin
          state_d = ST_DATA;
          cyc_d   = CW'(1);
          idx_d   = '0;
          tgt_d   = first_lim;
        end
      end
      ST_RECOV: begin
        if (!line_i)                          rcnt_d  = '0;
        else if (rcnt_q == recov_lim - RW'(1)) state_d = ST_IDLE;
        else                                  rcnt_d  = rcnt_q + RW'(1);
      end
      default: state_d = ST_RECOV;
    endcase
    if (err_set) begin
      state_d = ST_RECOV;
      rcnt_d  = '0;
      first_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cyc_q    <= '0;
      tgt_q    <= '0;
      period_q <= PW'(INIT_PERIOD);
      rcnt_q   <= '0;
      idx_q    <= '0;
      fcnt_q   <= 1'b0;
      first_q  <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      cyc_q    <= cyc_d;
      tgt_q    <= tgt_d;
      period_q <= period_d;
      rcnt_q   <= rcnt_d;
      idx_q    <= idx_d;
      fcnt_q   <= fcnt_d;
      first_q  <= first_d;
      err_q    <= err_set;
    end
  end

  assign error_o      = err_q;
  assign bit_period_o = period_q;

  // R1
  byte_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o |=> !byte_valid_o);
  // R2
  sof_qual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> byte_valid_o);
  // R8
  byte_err_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(byte_valid_o && error_o));
  // R4
  period_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(bit_period_o) |-> bit_period_o >= PW'(MIN_PERIOD));
  // R6
  recov_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RECOV) |=> (state_q == ST_RECOV || state_q == ST_IDLE));
  // R5
  pause_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_GAP) |-> (cyc_q <= pause_lim + CW'(1)));
endmodule

// File: tb/autobaud_line_rx_test.sv
module autobaud_line_rx_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line = 1'b1;
  logic [7:0] byte_o;
  logic       byte_valid_o, frame_start_o, error_o;
  logic [11:0] bit_period_o;

  int n_checks = 0;
  int n_err = 0;
  int n_valid = 0;
  int n_errpulse = 0;

  bit         exp_err_q[$];
  logic [7:0] exp_dat_q[$];
  bit         exp_sof_q[$];
  string      exp_tag_q[$];

  always #2 clk = ~clk;

  autobaud_line_rx uut (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .line_i        (line),
    .byte_o        (byte_o),
    .byte_valid_o  (byte_valid_o),
    .frame_start_o (frame_start_o),
    .error_o       (error_o),
    .bit_period_o  (bit_period_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic push_byte(input logic [7:0] d, input bit sof, input string tag);
    exp_err_q.push_back(1'b0);
    exp_dat_q.push_back(d);
    exp_sof_q.push_back(sof);
    exp_tag_q.push_back(tag);
  endtask

  task automatic push_err(input string tag);
    exp_err_q.push_back(1'b1);
    exp_dat_q.push_back(8'h00);
    exp_sof_q.push_back(1'b0);
    exp_tag_q.push_back(tag);
  endtask

  task automatic hold(input logic v, input int n);
    line = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b, input int t, input logic stop_v);
    hold(1'b0, t);
    for (int i = 0; i < 8; i++) hold(b[i], t);
    hold(stop_v, t);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && (byte_valid_o || error_o)) begin
      if (byte_valid_o) n_valid++;
      if (error_o) n_errpulse++;
      if (exp_err_q.size() == 0) begin
        chk(1'b0, "R1 unexpected output", int'(byte_o), -1);
      end else begin
        bit         e;
        logic [7:0] d;
        bit         s;
        string      t;
        e = exp_err_q.pop_front();
        d = exp_dat_q.pop_front();
        s = exp_sof_q.pop_front();
        t = exp_tag_q.pop_front();
        if (e) begin
          chk(error_o && !byte_valid_o, {t, " error"}, int'(error_o), 1);
        end else begin
          chk(byte_valid_o && byte_o == d, {t, " byte"}, int'(byte_o), int'(d));
          chk(frame_start_o == s, {t, " sof"}, int'(frame_start_o), int'(s));
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    int v0, e0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(!byte_valid_o && !frame_start_o && !error_o, "R10 outputs", int'(byte_valid_o), 0);
    chk(bit_period_o == 12'd16, "R10 period", int'(bit_period_o), 16);

    // R2 R3 R1: datagram at 16 clocks per bit
    push_byte(8'h05, 1'b1, "R2 sync byte t16");
    push_byte(8'h3C, 1'b0, "R3 t16");
    push_byte(8'hFF, 1'b0, "R3 t16");
    push_byte(8'h00, 1'b0, "R1 t16");
    send_byte(8'h05, 16, 1'b1);
    send_byte(8'h3C, 16, 1'b1);
    send_byte(8'hFF, 16, 1'b1);
    send_byte(8'h00, 16, 1'b1);
    chk(bit_period_o == 12'd16, "R2 period t16", int'(bit_period_o), 16);
    push_err("R5 timeout t16");
    hold(1'b1, 80 * 16);

    // R2 R3 R5: odd period, start exactly 63 periods after the previous start
    push_byte(8'hA5, 1'b1, "R2 sync byte t37");
    push_byte(8'h81, 1'b0, "R3 t37");
    push_byte(8'h5A, 1'b0, "R3 t37");
    push_byte(8'h7E, 1'b0, "R5 boundary start");
    send_byte(8'hA5, 37, 1'b1);
    send_byte(8'h81, 37, 1'b1);
    send_byte(8'h5A, 37, 1'b1);
    hold(1'b1, 53 * 37);
    send_byte(8'h7E, 37, 1'b1);
    chk(bit_period_o == 12'd37, "R2 period t37", int'(bit_period_o), 37);
    push_err("R5 timeout t37");
    hold(1'b1, 80 * 37);

    // R8: low stop bit on the sync byte (period becomes 20)
    push_err("R8 framing");
    send_byte(8'h15, 20, 1'b0);
    // R6: traffic during recovery is ignored
    v0 = n_valid;
    hold(1'b1, 6 * 20);
    send_byte(8'h05, 20, 1'b1);
    send_byte(8'h00, 20, 1'b1);
    hold(1'b1, 14 * 20);
    chk(n_valid == v0, "R6 ignored during recovery", n_valid - v0, 0);
    push_byte(8'h25, 1'b1, "R6 after recovery");
    push_byte(8'h99, 1'b0, "R3 t20");
    send_byte(8'h25, 20, 1'b1);
    send_byte(8'h99, 20, 1'b1);
    chk(bit_period_o == 12'd20, "R2 period t20", int'(bit_period_o), 20);
    push_err("R5 timeout t20");
    hold(1'b1, 80 * 20);

    // R7: 15-clock glitch
    push_err("R7 glitch 15");
    hold(1'b0, 15);
    hold(1'b1, 20 * 20);
    // R7 / R9: 16-clock pulse is a start bit, then sync never completes
    e0 = n_errpulse;
    hold(1'b0, 16);
    hold(1'b1, 1000);
    chk(n_errpulse == e0, "R7 16-clock pulse not glitch", n_errpulse - e0, 0);
    push_err("R9 sync saturation");
    hold(1'b1, 16383 + 12 * 20 + 100 - 1016);
    chk(n_errpulse == e0 + 1, "R9 saturation error", n_errpulse - e0, 1);

    // R4: sync span of 40 clocks is too fast
    push_err("R4 too fast");
    hold(1'b0, 16);
    hold(1'b1, 8);
    hold(1'b0, 8);
    hold(1'b1, 8);
    hold(1'b0, 8);
    hold(1'b1, 300);
    chk(bit_period_o == 12'd20, "R4 period kept", int'(bit_period_o), 20);

    // R2: minimum period accepted
    push_byte(8'h55, 1'b1, "R2 sync byte t16 again");
    push_byte(8'hC3, 1'b0, "R3 t16 again");
    send_byte(8'h55, 16, 1'b1);
    send_byte(8'hC3, 16, 1'b1);
    chk(bit_period_o == 12'd16, "R2 period min", int'(bit_period_o), 16);
    push_err("R5 timeout final");
    hold(1'b1, 80 * 16);

    chk(exp_err_q.size() == 0, "R1 all expected items seen", exp_err_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule